// File: doc/BRIEF.md
# Acknowledged Transaction Sequencer

This block is a control state machine that runs acknowledged radio transactions with no processor involvement. A transmit transaction proceeds in a fixed order. The machine first turns on the oscillator and synthesizer and waits until both report ready. It then sends the buffered packet and turns the link around to receive. After that it waits for an acknowledge until a programmable number of cycles has passed. It ends with a one-cycle completion pulse and a flag that says whether the acknowledge arrived or time ran out.

A receive transaction listens until a packet arrives with a passing CRC check. It then transmits an acknowledge and returns to listening for the next packet. The acknowledge carries only the 16-bit CRC of the packet it answers, with no length byte and no payload. That CRC reaches the transmitter on a valid/ready stream. The transmitter may hold `ack_ready` low for as long as it likes, and the field stays valid and unchanged until it is taken. The sequencer builds the acknowledge without selecting the transmit buffer. It allows writes to the receive buffer only while listening for data packets, so acknowledges never change either buffer.

Framing, CRC computation and buffer storage are handled by neighbouring blocks. This block only sequences their enables and takes in their handshakes.

Top module: `ats_sequencer`

## Requirements
- R1: While reset is held and after it is released, every enable, `done`, `acked` and `ack_valid` is low.
- R2: The cycle after `start_tx` is accepted, `osc_en` and `synth_en` go high. `tx_en` goes high with `txbuf_sel` only after a clock edge at which `osc_ready` and `synth_lock` are both high, and it stays high until `tx_done`.
- R3: The cycle after `tx_done` ends the data packet, `tx_en` is low and `rx_en` is high. `rx_en` and `tx_en` are never high together.
- R4: While waiting for an acknowledge, a packet with `rx_pkt_valid`, `rx_is_ack` and `rx_crc_ok` all high ends the transaction on the next cycle with `done` and `acked` high and every enable low. An acknowledge whose CRC check fails is ignored.
- R5: If no valid acknowledge arrives, `done` pulses with `acked` low after exactly `timeout_cycles` clock edges in the wait state, counted from its entry. A value of 0 counts as 1. An acknowledge on the expiring edge still wins.
- R6: In a receive transaction, a packet with `rx_pkt_valid` and `rx_crc_ok` high and `rx_is_ack` low switches the block to transmit on the next cycle. `ack_valid` is then high and `ack_data` equals that packet's `rx_crc`. Packets that fail the CRC check, and acknowledge packets, leave it listening.
- R7: `ack_valid` stays high with `ack_data` unchanged until a cycle with `ack_ready` high. On the cycle after that transfer, `ack_valid` is low.
- R8: When `tx_done` ends an acknowledge, the next cycle shows `rx_en` high, `tx_en` low, and a `done` pulse with `acked` high.
- R9: `done` is never high on two consecutive cycles.
- R10: `start_tx` and `start_rx` are ignored while a transaction is in progress. If both arrive together while idle, a transmit transaction starts.
- R11: The cycle after `abort` is high, every enable is low and `done` is low, whatever the state.
- R12: `txbuf_sel` is high only while the buffered data packet is being sent, never while an acknowledge is sent. `rxbuf_wr_en` is high only while listening for data packets in a receive transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_tx | input | 1 | Begin a transmit transaction (taken only while idle) |
| start_rx | input | 1 | Begin a receive transaction (taken only while idle) |
| abort | input | 1 | Return to idle and switch everything off |
| timeout_cycles | input | TW (16) | Acknowledge wait length in clock cycles |
| osc_ready | input | 1 | Oscillator is stable |
| synth_lock | input | 1 | Synthesizer has locked |
| tx_done | input | 1 | Transmitter finished the current packet |
| rx_pkt_valid | input | 1 | Receiver finished a packet (one-cycle strobe) |
| rx_is_ack | input | 1 | Finished packet is an acknowledge |
| rx_crc_ok | input | 1 | Finished packet passed its CRC check |
| rx_crc | input | 16 | CRC field of the finished packet |
| ack_ready | input | 1 | Transmitter accepts the acknowledge field |
| osc_en | output | 1 | Oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| tx_en | output | 1 | Transmitter enable |
| txbuf_sel | output | 1 | Transmitter sends from the transmit buffer |
| rx_en | output | 1 | Receiver enable |
| rxbuf_wr_en | output | 1 | Receiver may write the receive buffer |
| ack_valid | output | 1 | Acknowledge field is offered |
| ack_data | output | 16 | Acknowledge field (CRC of the answered packet) |
| done | output | 1 | One-cycle completion pulse |
| acked | output | 1 | With `done`: 1 = acknowledged, 0 = timed out |

## Verification
Every state change takes effect on the first cycle after the clock edge that sees its trigger, so enables, `ack_valid`, `ack_data`, `done` and `acked` are all due exactly one cycle after the input that causes them. The acknowledge timeout is due `timeout_cycles` edges after the wait state is entered. The bench steps a behavioural model on the same edge as the design and compares every output one time unit after each rising edge. Its directed checks drive inputs on falling edges and read results at the next falling edge. The timeout cases count edges from wait entry up to the `done` pulse and compare the count with the programmed length.

// File: rtl/ats_pkg.sv
package ats_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_TX_PKT,
    ST_ACK_WAIT,
    ST_RX_WAIT,
    ST_ACK_TX
  } ats_state_e;
endpackage

// File: rtl/ats_timeout.sv
module ats_timeout #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam logic [TW:0] ONE = {{TW{1'b0}}, 1'b1};
  logic [TW:0] cnt;

  // a limit of zero behaves as one: cnt+1 >= 0 holds on the first edge
  assign expire = run && ((cnt + ONE) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expire)   cnt <= cnt + ONE;
  end
endmodule

// File: rtl/ats_ack_field.sv
module ats_ack_field #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] crc_in,
  input  logic          active,
  input  logic          ack_ready,
  output logic          ack_valid,
  output logic [CW-1:0] ack_data
);
  logic pend;

  assign ack_valid = active && pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      ack_data <= '0;
    end else if (load) begin
      pend     <= 1'b1;
      ack_data <= crc_in;
    end else if (ack_valid && ack_ready) begin
      pend     <= 1'b0;
    end
  end
endmodule

// File: rtl/ats_fsm_core.sv
module ats_fsm_core
  import ats_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_tx,
  input  logic       start_rx,
  input  logic       abort,
  input  logic       osc_ready,
  input  logic       synth_lock,
  input  logic       tx_done,
  input  logic       rx_pkt_valid,
  input  logic       rx_is_ack,
  input  logic       rx_crc_ok,
  input  logic       expire,
  output ats_state_e state,
  output logic       ack_load,
  output logic       done,
  output logic       acked
);
  logic mode_tx;
  logic good_ack;

  assign good_ack = rx_pkt_valid && rx_is_ack && rx_crc_ok;
  assign ack_load = !abort && (state == ST_RX_WAIT) &&
                    rx_pkt_valid && rx_crc_ok && !rx_is_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_tx <= 1'b0;
      done    <= 1'b0;
      acked   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start_tx || start_rx) begin
              state   <= ST_WARM;
              mode_tx <= start_tx;
            end
          end
          ST_WARM: begin
            if (osc_ready && synth_lock)
              state <= mode_tx ? ST_TX_PKT : ST_RX_WAIT;
          end
          ST_TX_PKT: begin
            if (tx_done) state <= ST_ACK_WAIT;
          end
          ST_ACK_WAIT: begin
            if (good_ack || expire) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              acked <= good_ack;
            end
          end
          ST_RX_WAIT: begin
            if (ack_load) state <= ST_ACK_TX;
          end
          ST_ACK_TX: begin
            if (tx_done) begin
              state <= ST_RX_WAIT;
              done  <= 1'b1;
              acked <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ats_sequencer.sv
module ats_sequencer
  import ats_pkg::*;
#(
  parameter int TW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic          abort,
  input  logic [TW-1:0] timeout_cycles,
  input  logic          osc_ready,
  input  logic          synth_lock,
  input  logic          tx_done,
  input  logic          rx_pkt_valid,
  input  logic          rx_is_ack,
  input  logic          rx_crc_ok,
  input  logic [CW-1:0] rx_crc,
  input  logic          ack_ready,
  output logic          osc_en,
  output logic          synth_en,
  output logic          tx_en,
  output logic          txbuf_sel,
  output logic          rx_en,
  output logic          rxbuf_wr_en,
  output logic          ack_valid,
  output logic [CW-1:0] ack_data,
  output logic          done,
  output logic          acked
);
  ats_state_e state;
  logic       expire;
  logic       ack_load;

  ats_fsm_core u_core (
    .clk, .rst_n, .start_tx, .start_rx, .abort, .osc_ready, .synth_lock,
    .tx_done, .rx_pkt_valid, .rx_is_ack, .rx_crc_ok, .expire,
    .state, .ack_load, .done, .acked
  );

  ats_timeout #(.TW(TW)) u_timeout (
    .clk, .rst_n,
    .run    (state == ST_ACK_WAIT),
    .limit  (timeout_cycles),
    .expire
  );

  ats_ack_field #(.CW(CW)) u_ack (
    .clk, .rst_n,
    .load      (ack_load),
    .crc_in    (rx_crc),
    .active    (state == ST_ACK_TX),
    .ack_ready,
    .ack_valid,
    .ack_data
  );

  assign osc_en      = (state != ST_IDLE);
  assign synth_en    = (state != ST_IDLE);
  assign tx_en       = (state == ST_TX_PKT) || (state == ST_ACK_TX);
  assign txbuf_sel   = (state == ST_TX_PKT);
  assign rx_en       = (state == ST_ACK_WAIT) || (state == ST_RX_WAIT);
  assign rxbuf_wr_en = (state == ST_RX_WAIT);
endmodule

// File: rtl/ats_sequencer_chk.sv
module ats_sequencer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          osc_ready,
  input logic          synth_lock,
  input logic          tx_done,
  input logic          ack_ready,
  input logic          osc_en,
  input logic          synth_en,
  input logic          tx_en,
  input logic          txbuf_sel,
  input logic          rx_en,
  input logic          ack_valid,
  input logic [CW-1:0] ack_data,
  input logic          done
);
  assert_tx_needs_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (osc_en && synth_en));

  assert_tx_after_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && txbuf_sel) |-> $past(osc_ready && synth_lock));

  assert_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_sel && tx_done && !abort) |=> (rx_en && !tx_en));

  assert_no_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en));

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready && !abort && !tx_done) |=> (ack_valid && $stable(ack_data)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!tx_en && !rx_en && !synth_en && !osc_en && !done));

  assert_ack_not_buffer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (tx_en && !txbuf_sel));
endmodule

bind ats_sequencer ats_sequencer_chk #(.CW(CW)) u_chk (
  .clk, .rst_n, .abort, .osc_ready, .synth_lock, .tx_done, .ack_ready,
  .osc_en, .synth_en, .tx_en, .txbuf_sel, .rx_en, .ack_valid, .ack_data, .done
);

// File: tb/test_ats_sequencer.sv
`timescale 1ns/1ps
module test_ats_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_tx = 0, start_rx = 0, abort = 0;
  logic [15:0] timeout_cycles = 16'd50;
  logic        osc_ready = 0, synth_lock = 0, tx_done = 0;
  logic        rx_pkt_valid = 0, rx_is_ack = 0, rx_crc_ok = 0;
  logic [15:0] rx_crc = 16'h0;
  logic        ack_ready = 0;
  logic        osc_en, synth_en, tx_en, txbuf_sel, rx_en, rxbuf_wr_en;
  logic        ack_valid, done, acked;
  logic [15:0] ack_data;

  always #2 clk = ~clk;

  ats_sequencer i_ats_sequencer (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 warm-up,2 data tx,3 ack wait,4 listen,5 ack tx
  int          ph = 0, waited = 0;
  bit          mtx = 0, taken = 0, m_done = 0, m_acked = 0;
  logic [15:0] m_crc = 0;

  always @(posedge clk) begin
    bit nd, lim;
    nd = 0;
    if (!rst_n) begin
      ph = 0; waited = 0; m_done = 0; m_acked = 0; taken = 0;
    end else begin
      if (abort) ph = 0;
      else case (ph)
        0: if (start_tx || start_rx) begin ph = 1; mtx = start_tx; end
        1: if (osc_ready && synth_lock) ph = mtx ? 2 : 4;
        2: if (tx_done) begin ph = 3; waited = 0; end
        3: begin
          lim = (waited + 1 >= ((timeout_cycles == 0) ? 1 : int'(timeout_cycles)));
          if (rx_pkt_valid && rx_is_ack && rx_crc_ok) begin ph = 0; nd = 1; m_acked = 1; end
          else if (lim) begin ph = 0; nd = 1; m_acked = 0; end
          else waited++;
        end
        4: if (rx_pkt_valid && rx_crc_ok && !rx_is_ack) begin ph = 5; m_crc = rx_crc; taken = 0; end
        5: begin
          if (!taken && ack_ready) taken = 1;
          if (tx_done) begin ph = 4; nd = 1; m_acked = 1; end
        end
        default: ph = 0;
      endcase
      m_done = nd;
    end
  end

  always @(posedge clk) begin
    #1;
    chk(osc_en == (ph != 0) && synth_en == (ph != 0), "R2 clock enables", osc_en, ph != 0);
    chk(tx_en == (ph == 2 || ph == 5), "R2 tx_en", tx_en, ph == 2 || ph == 5);
    chk(rx_en == (ph == 3 || ph == 4), "R3 rx_en", rx_en, ph == 3 || ph == 4);
    chk(txbuf_sel == (ph == 2) && rxbuf_wr_en == (ph == 4), "R12 buffer selects",
        {txbuf_sel, rxbuf_wr_en}, {ph == 2, ph == 4});
    chk(ack_valid == (ph == 5 && !taken), "R7 ack_valid", ack_valid, ph == 5 && !taken);
    if (ack_valid) chk(ack_data == m_crc, "R6 ack_data", ack_data, m_crc);
    chk(done == m_done, "R9 done", done, m_done);
    if (done) chk(acked == m_acked, "R4 acked", acked, m_acked);
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pkt(input bit is_ack, input bit ok, input logic [15:0] crc);
    rx_pkt_valid = 1; rx_is_ack = is_ack; rx_crc_ok = ok; rx_crc = crc;
    tick();
    rx_pkt_valid = 0; rx_is_ack = 0; rx_crc_ok = 0;
  endtask

  task automatic pulse_done();
    tx_done = 1; tick(); tx_done = 0;
  endtask

  task automatic run_timeout(input logic [15:0] lim, input int exp);
    int n;
    timeout_cycles = lim;
    start_tx = 1; tick(); start_tx = 0;
    tick();
    pulse_done();
    n = 0;
    while (!done && n < 100) begin tick(); n++; end
    chk(n == exp && acked == 0, "R5 timeout length", n, exp);
  endtask

  initial begin
    tick(3);
    chk({osc_en, synth_en, tx_en, rx_en, done, acked, ack_valid} == 0, "R1 in reset",
        {osc_en, synth_en, tx_en, rx_en, done, acked, ack_valid}, 0);
    rst_n = 1; tick();
    chk({osc_en, tx_en, rx_en, done, acked, ack_valid} == 0, "R1 after reset",
        {osc_en, tx_en, rx_en, done, acked, ack_valid}, 0);

    // transmit transaction with staggered readiness
    start_tx = 1; tick(); start_tx = 0;
    chk(osc_en && synth_en && !tx_en, "R2 warm-up", {osc_en, synth_en, tx_en}, 3'b110);
    osc_ready = 1; tick(3);
    chk(!tx_en, "R2 waits for lock", tx_en, 0);
    synth_lock = 1; tick();
    chk(tx_en && txbuf_sel, "R2 tx from buffer", {tx_en, txbuf_sel}, 2'b11);
    tick(2);
    pulse_done();
    chk(rx_en && !tx_en && !rxbuf_wr_en, "R3 turnaround", {rx_en, tx_en, rxbuf_wr_en}, 3'b100);
    pkt(1, 0, 16'h1111);
    chk(rx_en && !done, "R4 bad ack ignored", {rx_en, done}, 2'b10);
    pkt(1, 1, 16'h2222);
    chk(done && acked && !rx_en && !osc_en, "R4 acknowledged", {done, acked, rx_en, osc_en}, 4'b1100);
    tick();
    chk(!done, "R9 single pulse", done, 0);

    // timeouts
    run_timeout(16'd5, 5);
    run_timeout(16'd0, 1);
    timeout_cycles = 16'd3;
    start_tx = 1; tick(); start_tx = 0;
    tick(); pulse_done(); tick(2);
    pkt(1, 1, 16'h3333);
    chk(done && acked, "R5 ack wins on expiry edge", {done, acked}, 2'b11);

    // simultaneous starts, then busy start and abort
    start_tx = 1; start_rx = 1; tick(); start_tx = 0; start_rx = 0;
    tick();
    chk(txbuf_sel, "R10 tx wins", txbuf_sel, 1);
    start_rx = 1; tick(); start_rx = 0;
    chk(txbuf_sel && !rx_en, "R10 start ignored in tx", {txbuf_sel, rx_en}, 2'b10);
    abort = 1; tick(); abort = 0;
    chk({osc_en, synth_en, tx_en, rx_en, done} == 0, "R11 abort in tx",
        {osc_en, synth_en, tx_en, rx_en, done}, 0);

    // receive transaction
    start_rx = 1; tick(); start_rx = 0;
    tick();
    chk(rx_en && rxbuf_wr_en, "R6 listening", {rx_en, rxbuf_wr_en}, 2'b11);
    pkt(0, 0, 16'hBEEF);
    chk(rx_en && !tx_en, "R6 bad crc ignored", {rx_en, tx_en}, 2'b10);
    pkt(1, 1, 16'hCAFE);
    chk(rx_en && !tx_en, "R6 ack packet ignored", {rx_en, tx_en}, 2'b10);
    start_tx = 1; tick(); start_tx = 0;
    chk(rx_en && !tx_en, "R10 start ignored in rx", {rx_en, tx_en}, 2'b10);
    pkt(0, 1, 16'hA5C3);
    chk(tx_en && !txbuf_sel && ack_valid && ack_data == 16'hA5C3, "R6 ack built",
        ack_data, 16'hA5C3);
    chk(!rxbuf_wr_en && !txbuf_sel, "R12 buffers untouched", {rxbuf_wr_en, txbuf_sel}, 0);
    tick(2);
    chk(ack_valid && ack_data == 16'hA5C3, "R7 held under back-pressure", ack_data, 16'hA5C3);
    ack_ready = 1; tick(); ack_ready = 0;
    chk(!ack_valid && tx_en, "R7 dropped after transfer", {ack_valid, tx_en}, 2'b01);
    pulse_done();
    chk(rx_en && !tx_en && done && acked, "R8 back to listening", {rx_en, tx_en, done, acked}, 4'b1011);
    pkt(0, 1, 16'h1234);
    abort = 1; tick(); abort = 0;
    chk({osc_en, tx_en, rx_en, ack_valid, done} == 0, "R11 abort in ack tx",
        {osc_en, tx_en, rx_en, ack_valid, done}, 0);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule